// File: doc/BRIEF.md
# Interruption State Capture Unit

This block records the processor context at the moment an interruption is delivered in a bundle-based instruction set, where each 16-byte bundle carries three instruction slots. On a one-cycle interruption strobe it stores a copy of the live status word, a return instruction address and a code vector of the traps that fired. The stored slot index and return address are chosen from the interruption class, the bundle kind and the instruction-set mode. All of this storage is gated by a collection-enable bit in the live status word.

In the same cycle the block presents the status word the handler should run with. That word has the default byte order, has most interruption enables cleared and keeps its translation enables. A priority picker also reports which single trap is delivered when several are raised together. The status word it receives is already serialized, so it carries any update that was still in flight.

Top module: `intr_capture_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no capture, `saved_stat_o`, `saved_ip_o` and `trap_code_o` are all zero.
- R2: A strobe with collection enable (status bit 0) at 0 leaves `saved_stat_o`, `saved_ip_o` and `trap_code_o` unchanged.
- R3: A strobe with collection enable at 1 copies `cur_stat_i` into `saved_stat_o` one cycle later, except the slot field (status bits 7:6), which takes the computed slot.
- R4: For a native trap (class 1), the saved slot is the next slot: slot+1 for slots 0 and 1. Slot 2 wraps to 0, and slot 1 of a long-immediate bundle (`long_bndl_i`=1) also goes to 0. Both wrap cases save `cur_ip_i`+16. The saved slot field is never 3.
- R5: For a native fault (class 0) or external interrupt (class 2), the saved slot is `slot_i`. For a long-immediate bundle, slot 2 is recorded as 1.
- R6: In legacy mode (`legacy_i`=1) the saved slot is 0. A legacy trap saves `next_ip_i` as the address.
- R7: Faults and external interrupts save `cur_ip_i`. A native trap without wrap also saves `cur_ip_i`.
- R8: On a capture, `trap_code_o` takes `trap_vec_i` (bit per fired trap) for class 1 and zero for the other classes.
- R9: `sel_trap_o` is one-hot on the lowest set bit of `trap_vec_i` (lower index is higher priority). `sel_valid_o` is 1 exactly when any bit is set. Both are zero when no bit is set.
- R10: `entry_stat_o` equals `cur_stat_i` with bit 2 (byte order) forced to `DEF_ENDIAN` and bits 0, 1 and 5 (collection, external interrupt and single-step enables) cleared. Translation bits 3 and 4 and all other bits pass unchanged.
- R11: Without a strobe, the saved registers hold whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| intr_stb_i | input | 1 | One-cycle interruption strobe |
| cls_i | input | 2 | Class: 0 fault, 1 trap, 2 external interrupt |
| legacy_i | input | 1 | Interrupted code runs the legacy 32-bit set |
| long_bndl_i | input | 1 | Bundle holds a two-slot long-immediate instruction |
| slot_i | input | 2 | Slot index of the interrupted instruction |
| cur_stat_i | input | SW | Live status word, already serialized |
| cur_ip_i | input | IPW | Address of the interrupted instruction or bundle |
| next_ip_i | input | IPW | Address after the instruction (legacy traps) |
| trap_vec_i | input | NTRAP | Traps raised together |
| entry_stat_o | output | SW | Status word for handler entry |
| saved_stat_o | output | SW | Saved status register |
| saved_ip_o | output | IPW | Saved instruction address |
| trap_code_o | output | NTRAP | Trap code register |
| sel_trap_o | output | NTRAP | Delivered trap, one-hot |
| sel_valid_o | output | 1 | A trap is selected |

## Verification
Captures are tried over each class crossed with normal and long-immediate bundles and with native and legacy mode. This separates the next-slot rule from the current-slot rule, and it exposes the two wrap cases where the address must step by one bundle. A capture with collection disabled and an idle cycle with changing inputs show that the stored context survives. Trap vectors with several bits, a single high bit and no bits set separate a correct priority pick from a wrong one, and they test the all-zero case. Several status patterns show which bits the handler-entry word changes and which it preserves.

// File: rtl/intr_capture_pkg.sv
package intr_capture_pkg;
  localparam logic [1:0] CLS_FAULT = 2'd0;
  localparam logic [1:0] CLS_TRAP  = 2'd1;
  localparam logic [1:0] CLS_EXT   = 2'd2;

  localparam int ST_COLL    = 0;
  localparam int ST_IRQ     = 1;
  localparam int ST_ENDIAN  = 2;
  localparam int ST_DXL     = 3;
  localparam int ST_IXL     = 4;
  localparam int ST_STEP    = 5;
  localparam int ST_SLOT_LO = 6;

  localparam int SLOT_W       = 2;
  localparam int LAST_SLOT    = 2;
  localparam int BUNDLE_BYTES = 16;
endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int NTRAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTRAP-1:0] vec_i,
  output logic [NTRAP-1:0] sel_o,
  output logic             valid_o
);
  logic [NTRAP:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NTRAP; i++) begin : g_chain
    assign seen[i+1] = seen[i] | vec_i[i];
    assign sel_o[i]  = vec_i[i] & ~seen[i];
  end
  assign valid_o = seen[NTRAP];

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_subset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o & ~vec_i) == '0);
  p_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (vec_i != '0));
endmodule

// File: rtl/slot_ip_calc.sv
module slot_ip_calc
  import intr_capture_pkg::*;
#(
  parameter int IPW = 64
) (
  input  logic [1:0]        cls_i,
  input  logic              legacy_i,
  input  logic              long_bndl_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [IPW-1:0]    cur_ip_i,
  input  logic [IPW-1:0]    next_ip_i,
  output logic [SLOT_W-1:0] sv_slot_o,
  output logic [IPW-1:0]    sv_ip_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LAST_SLOT);
  localparam logic [IPW-1:0]    STEP = IPW'(BUNDLE_BYTES);

  logic is_trap;
  logic wrap;

  assign is_trap = (cls_i == CLS_TRAP);
  assign wrap    = (slot_i >= LAST) || (long_bndl_i && slot_i == SLOT_W'(1));

  always_comb begin
    sv_slot_o = slot_i;
    sv_ip_o   = cur_ip_i;
    if (legacy_i) begin
      sv_slot_o = '0;
      sv_ip_o   = is_trap ? next_ip_i : cur_ip_i;
    end else if (is_trap) begin
      if (wrap) begin
        sv_slot_o = '0;
        sv_ip_o   = cur_ip_i + STEP;
      end else begin
        sv_slot_o = slot_i + SLOT_W'(1);
      end
    end else if (slot_i >= LAST) begin
      sv_slot_o = long_bndl_i ? SLOT_W'(1) : LAST;
    end
  end
endmodule

// File: rtl/entry_status.sv
module entry_status
  import intr_capture_pkg::*;
#(
  parameter int             SW         = 16,
  parameter logic           DEF_ENDIAN = 1'b0,
  parameter logic [SW-1:0]  CLR_MASK   = SW'(35)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] stat_i,
  output logic [SW-1:0] stat_o
);
  always_comb begin
    stat_o            = stat_i & ~CLR_MASK;
    stat_o[ST_ENDIAN] = DEF_ENDIAN;
  end

  p_entry_masks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[ST_COLL] && !stat_o[ST_IRQ] && stat_o[ST_ENDIAN] == DEF_ENDIAN);
  p_entry_xlat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[ST_DXL] == stat_i[ST_DXL] && stat_o[ST_IXL] == stat_i[ST_IXL]);
endmodule

// File: rtl/intr_capture_unit.sv
module intr_capture_unit
  import intr_capture_pkg::*;
#(
  parameter int             SW         = 16,
  parameter int             IPW        = 64,
  parameter int             NTRAP      = 4,
  parameter logic           DEF_ENDIAN = 1'b0,
  parameter logic [SW-1:0]  CLR_MASK   = SW'(35)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             intr_stb_i,
  input  logic [1:0]       cls_i,
  input  logic             legacy_i,
  input  logic             long_bndl_i,
  input  logic [1:0]       slot_i,
  input  logic [SW-1:0]    cur_stat_i,
  input  logic [IPW-1:0]   cur_ip_i,
  input  logic [IPW-1:0]   next_ip_i,
  input  logic [NTRAP-1:0] trap_vec_i,
  output logic [SW-1:0]    entry_stat_o,
  output logic [SW-1:0]    saved_stat_o,
  output logic [IPW-1:0]   saved_ip_o,
  output logic [NTRAP-1:0] trap_code_o,
  output logic [NTRAP-1:0] sel_trap_o,
  output logic             sel_valid_o
);
  localparam logic [SW-1:0] SLOT_MASK = SW'({SLOT_W{1'b1}}) << ST_SLOT_LO;

  logic [SLOT_W-1:0] sv_slot;
  logic [IPW-1:0]    sv_ip;
  logic              cap_en;
  logic [SW-1:0]     stat_d, stat_q;
  logic [IPW-1:0]    ip_d, ip_q;
  logic [NTRAP-1:0]  code_d, code_q;

  slot_ip_calc #(.IPW(IPW)) u_slot (
    .cls_i      (cls_i),
    .legacy_i   (legacy_i),
    .long_bndl_i(long_bndl_i),
    .slot_i     (slot_i),
    .cur_ip_i   (cur_ip_i),
    .next_ip_i  (next_ip_i),
    .sv_slot_o  (sv_slot),
    .sv_ip_o    (sv_ip)
  );

  entry_status #(.SW(SW), .DEF_ENDIAN(DEF_ENDIAN), .CLR_MASK(CLR_MASK)) u_entry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(cur_stat_i),
    .stat_o(entry_stat_o)
  );

  trap_prio_pick #(.NTRAP(NTRAP)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (trap_vec_i),
    .sel_o  (sel_trap_o),
    .valid_o(sel_valid_o)
  );

  // next-state
  always_comb begin
    cap_en = intr_stb_i & cur_stat_i[ST_COLL];
    stat_d = cur_stat_i;
    stat_d[ST_SLOT_LO +: SLOT_W] = sv_slot;
    ip_d   = sv_ip;
    code_d = (cls_i == CLS_TRAP) ? trap_vec_i : '0;
  end

  // registers with explicit clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ip_q   <= '0;
      code_q <= '0;
    end else if (cap_en) begin
      stat_q <= stat_d;
      ip_q   <= ip_d;
      code_q <= code_d;
    end
  end

  assign saved_stat_o = stat_q;
  assign saved_ip_o   = ip_q;
  assign trap_code_o  = code_q;

  p_hold_nocoll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_stb_i && !cur_stat_i[ST_COLL] |=>
      $stable(stat_q) && $stable(ip_q) && $stable(code_q));
  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intr_stb_i |=> $stable(stat_q) && $stable(ip_q) && $stable(code_q));
  p_copy_stat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_stb_i && cur_stat_i[ST_COLL] |=>
      (stat_q & ~SLOT_MASK) == ($past(cur_stat_i) & ~SLOT_MASK));
  p_slot_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[ST_SLOT_LO +: SLOT_W] != SLOT_W'(3));
  p_legacy_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_stb_i && cur_stat_i[ST_COLL] && legacy_i |=>
      stat_q[ST_SLOT_LO +: SLOT_W] == '0);
  p_code_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_stb_i && cur_stat_i[ST_COLL] && cls_i != CLS_TRAP |=> code_q == '0);
endmodule

// File: tb/intr_capture_unit_tb_top.sv
module intr_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stb;
  logic [1:0]  cls;
  logic        leg, lng;
  logic [1:0]  slot;
  logic [15:0] stat;
  logic [63:0] ip, nip;
  logic [3:0]  tv;
  logic [15:0] entry_stat, sv_stat;
  logic [63:0] sv_ip;
  logic [3:0]  code, sel;
  logic        sel_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] st;
    logic [63:0] ip;
    logic [3:0]  code;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [15:0] m_st;
  logic [63:0] m_ip;
  logic [3:0]  m_code;

  always #4 clk = ~clk;

  intr_capture_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .intr_stb_i(stb), .cls_i(cls),
    .legacy_i(leg), .long_bndl_i(lng), .slot_i(slot), .cur_stat_i(stat),
    .cur_ip_i(ip), .next_ip_i(nip), .trap_vec_i(tv),
    .entry_stat_o(entry_stat), .saved_stat_o(sv_stat), .saved_ip_o(sv_ip),
    .trap_code_o(code), .sel_trap_o(sel), .sel_valid_o(sel_v)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: drives one cycle, checks combinational outputs, pushes expectation
  task automatic intr(input bit s, input logic [1:0] c, input bit l, input bit lb,
                      input logic [1:0] sl, input logic [15:0] st,
                      input logic [63:0] a, input logic [63:0] na,
                      input logic [3:0] t, input string tag);
    logic [1:0]  es;
    logic [63:0] ea;
    logic [15:0] ee;
    logic [3:0]  esel;
    exp_t e;
    @(negedge clk);
    stb = s; cls = c; leg = l; lng = lb; slot = sl; stat = st; ip = a; nip = na; tv = t;
    #1;
    ee = st & ~16'h0023; ee[2] = 1'b0;
    chk({"R10 entry ", tag}, 64'(entry_stat), 64'(ee));
    esel = '0;
    for (int i = 3; i >= 0; i--) if (t[i]) esel = 4'(1 << i);
    chk({"R9 sel ", tag}, 64'({sel_v, sel}), 64'({t != 0, esel}));
    if (s && st[0]) begin
      es = sl; ea = a;
      if (l) begin es = 0; if (c == 2'd1) ea = na; end
      else if (c == 2'd1) begin
        if (sl == 2 || (lb && sl == 1)) begin es = 0; ea = a + 64'd16; end
        else es = sl + 2'd1;
      end else if (lb && sl == 2) es = 1;
      m_st = st; m_st[7:6] = es; m_ip = ea; m_code = (c == 2'd1) ? t : 4'd0;
    end
    e.st = m_st; e.ip = m_ip; e.code = m_code; e.tag = tag;
    #1 q.push_back(e);
  endtask

  // monitor: compares registered outputs after the capturing edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({"stat ", e.tag}, 64'(sv_stat), 64'(e.st));
        chk({"ip ", e.tag}, sv_ip, e.ip);
        chk({"code ", e.tag}, 64'(code), 64'(e.code));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stb = 0; cls = 0; leg = 0; lng = 0; slot = 0;
    stat = 0; ip = 0; nip = 0; tv = 0;
    m_st = 0; m_ip = 0; m_code = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset stat", 64'(sv_stat), 64'd0);
    chk("R1 reset ip", sv_ip, 64'd0);
    chk("R1 reset code", 64'(code), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 64'({sv_stat, code}), 64'd0);

    intr(1, 2'd0, 0, 0, 2'd1, 16'hA41D, 64'h1000, 64'h0, 4'b0000, "R3 R5 R7 R8 fault slot1");
    intr(1, 2'd1, 0, 0, 2'd0, 16'h5F19, 64'h2000, 64'h0, 4'b0110, "R4 R7 R8 trap slot0");
    intr(1, 2'd1, 0, 0, 2'd2, 16'h00DF, 64'h3000, 64'h0, 4'b1001, "R4 trap slot2 wrap");
    intr(1, 2'd1, 0, 1, 2'd1, 16'hFFFF, 64'h4FF0, 64'h0, 4'b1000, "R4 long trap slot1");
    intr(1, 2'd0, 0, 1, 2'd2, 16'h0019, 64'h5000, 64'h0, 4'b0001, "R5 long fault slot2");
    intr(1, 2'd2, 0, 0, 2'd2, 16'h1203, 64'h6000, 64'h0, 4'b1111, "R5 R8 ext slot2");
    intr(1, 2'd1, 0, 1, 2'd0, 16'h0001, 64'h6100, 64'h0, 4'b0100, "R4 long trap slot0");
    intr(1, 2'd1, 1, 0, 2'd2, 16'h0C1F, 64'h7000, 64'h7003, 4'b0010, "R6 legacy trap");
    intr(1, 2'd0, 1, 0, 2'd1, 16'h0C5D, 64'h8000, 64'h8005, 4'b0000, "R6 R7 legacy fault");
    intr(1, 2'd1, 0, 0, 2'd1, 16'hFFFE, 64'h9000, 64'h9010, 4'b0111, "R2 collection off");
    intr(0, 2'd1, 1, 1, 2'd0, 16'hFFFF, 64'hA000, 64'hA004, 4'b1010, "R11 idle");
    intr(0, 2'd2, 0, 0, 2'd2, 16'h0004, 64'hB000, 64'h0, 4'b0000, "R11 R9 idle none");
    intr(1, 2'd2, 0, 1, 2'd0, 16'h801B, 64'hC000, 64'h0, 4'b1100, "R5 R8 ext long slot0");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule